// File: doc/BRIEF.md
# Capture-Delay Tap Window Calibrator

This block tunes the input delay applied to a source-synchronous ADC data bus. After a single-cycle `start` pulse, it steps a programmable delay line through every tap in ascending order. At each tap it tests the I channel and then the Q channel, using an external ramp-pattern checker. For each test it switches the ADC into a test mode, restarts the checker, waits a programmable dwell, and then samples the checker's lock and error flags. A tap is good only when both channels are good.

The sequencer tracks a window of good taps. The window opens at the first good tap and its upper edge follows every later good tap. Once a failing tap closes a window that is wide enough, the sweep stops early. If calibration succeeds, the midpoint of the window is loaded into the delay line. Whatever the outcome, the ADC returns to normal mode and the checker is switched off. A one-cycle `done` pulse then reports a status code, the tap presented on `dly_tap` and the window width.

States: IDLE (wait for start), LOAD (strobe sweep tap), CHK_OFF (checker off, test mode set), CHK_ON (checker on, dwell loaded), DWELL (wait), JUDGE (sample channel), STEP (decide next tap or end), APPLY (strobe midpoint), FINISH (done pulse). Transitions: IDLE→LOAD on start; LOAD→CHK_OFF→CHK_ON→DWELL; DWELL→JUDGE when the dwell expires; JUDGE→CHK_OFF after I, JUDGE→STEP after Q; STEP→LOAD for the next tap, STEP→APPLY on success, STEP→FINISH on failure; APPLY→FINISH; FINISH→IDLE.

Top module: `tap_window_cal`

## Requirements
- R1: Out of reset, `dly_tap` is 16 (mid-scale), and `busy`, `done`, `dly_load` and `chk_enable` are low, with `test_mode` 0 (normal).
- R2: A `start` pulse while idle makes `busy` high on the next cycle. A `start` while busy has no effect on the run in progress.
- R3: The sweep presents taps 0, 1, 2, … in ascending order, each with a `dly_load` strobe high for exactly one cycle.
- R4: At each tap, the I test (`test_mode` 1 = ramp on I, all ones on Q) runs before the Q test (`test_mode` 2 = all ones on I, ramp on Q). Before each test `chk_enable` is low for at least one cycle. It then stays high for DWELL_CYCLES+2 cycles, and the flags are sampled in the last of those cycles.
- R5: A channel passes only with lock high and error low; a missing lock is a fail. The window start is the first tap where both channels pass, and the window stop is the latest such tap. `win_width` equals stop − start.
- R6: A failing tap ends the sweep early when a window is open and stop − start ≥ 4. Otherwise the sweep continues up to tap 31.
- R7: If no tap passes, `status` is 1 (no convergence), `win_width` is 0 and `dly_tap` holds the last swept tap.
- R8: If stop − start < 4, `status` is 2 (window too narrow) and `dly_tap` holds the last swept tap.
- R9: On success, `status` is 0 and floor((start+stop)/2) is presented on `dly_tap` with one more strobe before `done`.
- R10: `done` is a one-cycle pulse. During it, `test_mode` is 0 and `chk_enable` is low, and `busy` is low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle calibration launch |
| chk_lock_i | input | 1 | I checker locked |
| chk_err_i | input | 1 | I checker saw a deviation |
| chk_lock_q | input | 1 | Q checker locked |
| chk_err_q | input | 1 | Q checker saw a deviation |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 no convergence, 2 too narrow |
| dly_tap | output | TAP_W | Tap value presented to the delay line |
| dly_load | output | 1 | Delay line load strobe |
| chk_enable | output | 1 | Checker enable (low→high restarts it) |
| test_mode | output | 2 | ADC pattern select: 0 normal, 1 ramp I, 2 ramp Q |
| win_width | output | TAP_W | Window stop − start |

## Verification
The assertions take for granted that `start` is a single-cycle pulse and that the checker flags are meaningful only while their channel's test mode is active. The bench models the checker against the tap last strobed into the delay line: a good tap gives lock with no error, and a bad tap gives either no lock or a lock with an error, alternating between taps. The flags of a channel read as unlocked whenever its ramp mode is not selected, so a sequencer that samples the wrong channel or the wrong mode is caught. Start pulses are single cycles, and one extra pulse is issued mid-run to probe that it is ignored.

// File: rtl/tap_cal_pkg.sv
package tap_cal_pkg;
    typedef enum logic [1:0] {
        CAL_OK     = 2'd0,
        CAL_NOCONV = 2'd1,
        CAL_NARROW = 2'd2
    } cal_status_e;

    typedef enum logic [1:0] {
        TM_NORMAL = 2'd0,
        TM_RAMP_I = 2'd1,
        TM_RAMP_Q = 2'd2
    } test_mode_e;

    typedef enum logic [3:0] {
        S_IDLE, S_LOAD, S_CHK_OFF, S_CHK_ON, S_DWELL,
        S_JUDGE, S_STEP, S_APPLY, S_FINISH
    } cal_state_e;
endpackage

// File: rtl/dwell_timer.sv
module dwell_timer #(
    parameter int CNT_W        = 21,
    parameter int DWELL_CYCLES = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(DWELL_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= RELOAD;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/win_tracker.sv
module win_tracker #(
    parameter int TAP_W    = 5,
    parameter int MIN_SPAN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             upd,
    input  logic             pass,
    input  logic [TAP_W-1:0] tap,
    output logic             is_open,
    output logic             wide,
    output logic [TAP_W-1:0] span,
    output logic [TAP_W-1:0] centre
);
    logic [TAP_W-1:0] w_lo, w_hi;
    logic [TAP_W:0]   sum;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            is_open <= 1'b0;
            w_lo    <= '0;
            w_hi    <= '0;
        end else if (upd && pass) begin
            if (!is_open) begin
                is_open <= 1'b1;
                w_lo    <= tap;
            end
            w_hi <= tap;
        end
    end

    assign span   = w_hi - w_lo;
    assign wide   = ({1'b0, span} >= (TAP_W+1)'(MIN_SPAN));
    assign sum    = {1'b0, w_lo} + {1'b0, w_hi};
    assign centre = sum[TAP_W:1];
endmodule

// File: rtl/tap_window_cal.sv
module tap_window_cal
    import tap_cal_pkg::*;
#(
    parameter int TAP_W        = 5,
    parameter int CNT_W        = 21,
    parameter int DWELL_CYCLES = 2_000_000,
    parameter int MIN_SPAN     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             chk_lock_i,
    input  logic             chk_err_i,
    input  logic             chk_lock_q,
    input  logic             chk_err_q,
    output logic             busy,
    output logic             done,
    output logic [1:0]       status,
    output logic [TAP_W-1:0] dly_tap,
    output logic             dly_load,
    output logic             chk_enable,
    output logic [1:0]       test_mode,
    output logic [TAP_W-1:0] win_width
);
    localparam logic [TAP_W-1:0] LAST_TAP = {TAP_W{1'b1}};
    localparam logic [TAP_W-1:0] MID_TAP  = TAP_W'(1 << (TAP_W - 1));

    cal_state_e       state, nxt;
    cal_status_e      stat_q;
    logic [TAP_W-1:0] sweep_tap;
    logic             chan_q, pass_i, tap_pass;
    logic             expired, trk_clear, trk_upd, q_pass;
    logic             is_open, wide, end_sweep;
    logic [TAP_W-1:0] span, centre;

    assign q_pass    = pass_i && chk_lock_q && !chk_err_q;
    assign trk_clear = (state == S_IDLE) && start;
    assign trk_upd   = (state == S_JUDGE) && chan_q;
    assign end_sweep = (!tap_pass && is_open && wide) || (sweep_tap == LAST_TAP);

    dwell_timer #(.CNT_W(CNT_W), .DWELL_CYCLES(DWELL_CYCLES)) i_dwell (
        .clk(clk), .rst_n(rst_n),
        .load(state == S_CHK_ON), .run(state == S_DWELL),
        .expired(expired)
    );

    win_tracker #(.TAP_W(TAP_W), .MIN_SPAN(MIN_SPAN)) i_win (
        .clk(clk), .rst_n(rst_n), .clear(trk_clear),
        .upd(trk_upd), .pass(q_pass), .tap(sweep_tap),
        .is_open(is_open), .wide(wide), .span(span), .centre(centre)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (start) nxt = S_LOAD;
            S_LOAD:    nxt = S_CHK_OFF;
            S_CHK_OFF: nxt = S_CHK_ON;
            S_CHK_ON:  nxt = S_DWELL;
            S_DWELL:   if (expired) nxt = S_JUDGE;
            S_JUDGE:   nxt = chan_q ? S_STEP : S_CHK_OFF;
            S_STEP: begin
                if (!end_sweep)               nxt = S_LOAD;
                else if (is_open && wide)     nxt = S_APPLY;
                else                          nxt = S_FINISH;
            end
            S_APPLY:   nxt = S_FINISH;
            S_FINISH:  nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // State register and sweep datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            sweep_tap <= '0;
            chan_q    <= 1'b0;
            pass_i    <= 1'b0;
            tap_pass  <= 1'b0;
            stat_q    <= CAL_OK;
            dly_tap   <= MID_TAP;
        end else begin
            state <= nxt;
            unique case (state)
                S_IDLE: if (start) begin
                    sweep_tap <= '0;
                    dly_tap   <= '0;
                    chan_q    <= 1'b0;
                end
                S_JUDGE: begin
                    if (!chan_q) begin
                        pass_i <= chk_lock_i && !chk_err_i;
                        chan_q <= 1'b1;
                    end else begin
                        tap_pass <= q_pass;
                        chan_q   <= 1'b0;
                    end
                end
                S_STEP: begin
                    if (!end_sweep) begin
                        sweep_tap <= sweep_tap + 1'b1;
                        dly_tap   <= sweep_tap + 1'b1;
                    end else if (!is_open) begin
                        stat_q <= CAL_NOCONV;
                    end else if (!wide) begin
                        stat_q <= CAL_NARROW;
                    end else begin
                        stat_q  <= CAL_OK;
                        dly_tap <= centre;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs decoded from state
    always_comb begin
        busy       = (state != S_IDLE);
        done       = (state == S_FINISH);
        dly_load   = (state == S_LOAD) || (state == S_APPLY);
        chk_enable = (state == S_CHK_ON) || (state == S_DWELL) || (state == S_JUDGE);
        test_mode  = TM_NORMAL;
        unique case (state)
            S_CHK_OFF, S_CHK_ON, S_DWELL, S_JUDGE:
                test_mode = chan_q ? TM_RAMP_Q : TM_RAMP_I;
            default: ;
        endcase
        status    = stat_q;
        win_width = span;
    end
endmodule

// File: rtl/cal_checker.sv
module cal_checker #(
    parameter int TAP_W    = 5,
    parameter int MIN_SPAN = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [1:0]       status,
    input logic             dly_load,
    input logic             chk_enable,
    input logic [1:0]       test_mode,
    input logic [TAP_W-1:0] win_width
);
    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dly_load |=> !dly_load);

    assert_busy_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_mode_when_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chk_enable |-> (test_mode == 2'd1 || test_mode == 2'd2));

    assert_mode_settled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chk_enable) |-> $stable(test_mode));

    assert_ok_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 2'd0) |-> ({1'b0, win_width} >= (TAP_W+1)'(MIN_SPAN)));

    assert_narrow_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 2'd2) |-> ({1'b0, win_width} < (TAP_W+1)'(MIN_SPAN)));

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (test_mode == 2'd0 && !chk_enable) ##1 (!busy && !done));

    assert_no_done_without_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
endmodule

bind tap_window_cal cal_checker #(.TAP_W(TAP_W), .MIN_SPAN(MIN_SPAN)) i_cal_checker (.*);

// File: tb/test_tap_window_cal.sv
module test_tap_window_cal;
    localparam int TAP_W = 5;
    localparam int DWELL = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic chk_lock_i, chk_err_i, chk_lock_q, chk_err_q;
    logic busy, done, dly_load, chk_enable;
    logic [1:0] status, test_mode;
    logic [TAP_W-1:0] dly_tap, win_width;

    always #4 clk = ~clk;

    tap_window_cal #(.TAP_W(TAP_W), .CNT_W(4), .DWELL_CYCLES(DWELL), .MIN_SPAN(4)) i_tap_window_cal (
        .clk(clk), .rst_n(rst_n), .start(start),
        .chk_lock_i(chk_lock_i), .chk_err_i(chk_err_i),
        .chk_lock_q(chk_lock_q), .chk_err_q(chk_err_q),
        .busy(busy), .done(done), .status(status), .dly_tap(dly_tap),
        .dly_load(dly_load), .chk_enable(chk_enable), .test_mode(test_mode),
        .win_width(win_width)
    );

    // Delay line and pattern checker model
    logic [31:0] mask_i = '0, mask_q = '0;
    logic [4:0]  applied;
    always @(posedge clk) begin
        if (!rst_n) applied <= 5'd16;
        else if (dly_load) applied <= dly_tap;
    end
    assign chk_lock_i = (test_mode == 2'd1) && (mask_i[applied] || applied[0]);
    assign chk_err_i  = (test_mode == 2'd1) && !mask_i[applied] && applied[0];
    assign chk_lock_q = (test_mode == 2'd2) && (mask_q[applied] || applied[0]);
    assign chk_err_q  = (test_mode == 2'd2) && !mask_q[applied] && applied[0];

    int checks = 0, errors = 0, runs_done = 0, cycles = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    typedef struct {
        int st; int tap; int width; int last; int loads;
    } exp_t;
    exp_t sb[$];

    function automatic exp_t predict(input logic [31:0] mi, input logic [31:0] mq);
        exp_t e;
        int ws = -1, we = -1, last = 0;
        for (int t = 0; t < 32; t++) begin
            last = t;
            if (mi[t] && mq[t]) begin
                if (ws < 0) ws = t;
                we = t;
            end else if (ws >= 0 && we - ws >= 4) begin
                break;
            end
        end
        e.last = last;
        if (ws < 0) begin
            e.st = 1; e.width = 0; e.tap = last; e.loads = last + 1;
        end else if (we - ws < 4) begin
            e.st = 2; e.width = we - ws; e.tap = last; e.loads = last + 1;
        end else begin
            e.st = 0; e.width = we - ws; e.tap = (ws + we) / 2; e.loads = last + 2;
        end
        return e;
    endfunction

    function automatic logic [31:0] span_mask(input int lo, input int hi);
        logic [31:0] m = '0;
        for (int t = lo; t <= hi; t++) m[t] = 1'b1;
        return m;
    endfunction

    // Monitor
    int  load_q[$];
    int  en_run = 0, en_bad = 0, mode_bad = 0, test_idx = 0;
    bit  en_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (dly_load) load_q.push_back(int'(dly_tap));
            if (chk_enable) begin
                if (!en_prev) begin
                    if (int'(test_mode) != ((test_idx % 2) ? 2 : 1)) mode_bad++;
                    test_idx++;
                    en_run = 0;
                end
                en_run++;
            end else if (en_prev && en_run != DWELL + 2) begin
                en_bad++;
            end
            en_prev = chk_enable;
            if (done) begin
                exp_t e;
                bit order_ok = 1'b1;
                e = sb.pop_front();
                check(int'(status) == e.st,
                      (e.st == 0) ? "R9 status" : (e.st == 1) ? "R7 status" : "R8 status",
                      int'(status), e.st);
                check(int'(dly_tap) == e.tap, "R9 final tap", int'(dly_tap), e.tap);
                check(int'(applied) == e.tap, "R9 delay line holds final tap", int'(applied), e.tap);
                check(int'(win_width) == e.width, "R5 window width", int'(win_width), e.width);
                check(load_q.size() == e.loads, "R6 sweep length (strobes)", load_q.size(), e.loads);
                for (int k = 0; k <= e.last && k < load_q.size(); k++)
                    if (load_q[k] != k) order_ok = 1'b0;
                check(order_ok, "R3 ascending tap order", 0, 0);
                check(test_idx == 2 * (e.last + 1), "R4 test count", test_idx, 2 * (e.last + 1));
                check(mode_bad == 0, "R4 I then Q mode order", mode_bad, 0);
                check(en_bad == 0, "R4 enable dwell length", en_bad, 0);
                check(test_mode == 2'd0 && !chk_enable, "R10 normal mode at done",
                      int'(test_mode), 0);
                load_q.delete();
                en_bad = 0; mode_bad = 0; test_idx = 0;
                runs_done++;
            end
        end
    end

    task automatic run_case(input logic [31:0] mi, input logic [31:0] mq, input bit poke);
        int target = runs_done + 1;
        mask_i = mi;
        mask_q = mq;
        sb.push_back(predict(mi, mq));
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        if (poke) begin
            repeat (60) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        while (runs_done < target) @(negedge clk);
        @(negedge clk);
        check(!busy && !done, "R10 idle after done", int'(busy), 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(dly_tap == 5'd16, "R1 reset tap", int'(dly_tap), 16);
        check(!busy && !done && !dly_load && !chk_enable && test_mode == 2'd0,
              "R1 reset outputs", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dly_tap == 5'd16 && !busy, "R1 idle after reset", int'(dly_tap), 16);

        run_case(span_mask(8, 20), span_mask(8, 20), 1'b1);                      // R2 start ignored
        run_case('0, '0, 1'b0);                                                   // R7
        run_case(span_mask(5, 7), span_mask(5, 7), 1'b0);                         // R8
        run_case(span_mask(3, 6) | span_mask(10, 25),
                 span_mask(3, 6) | span_mask(10, 25), 1'b0);                      // R5 stop follows
        run_case(span_mask(27, 31), span_mask(27, 31), 1'b0);                     // R6 edge width 4
        run_case('1, span_mask(0, 11), 1'b0);                                     // Q decides
        run_case(span_mask(0, 11), '1, 1'b0);                                     // I decides
        run_case(span_mask(10, 13), span_mask(10, 13), 1'b0);                     // R8 width 3

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule